// File: doc/BRIEF.md
# Segment Base Linear Address Generator

This block turns a segment index and an effective-address offset into a linear address. It keeps a small table with one entry per segment register. Each entry holds a 16-bit selector, a cached base and a cached limit. The base and limit arrive directly on a load port together with the selector. No descriptor is fetched from memory.

A mode input picks legacy or 64-bit behaviour. In legacy mode the block adds a 32-bit base to the low 32 bits of the offset and checks the offset against the stored limit. In 64-bit mode four of the six segments are treated as flat with a base of zero, and the two remaining segments add their full stored base. No limit check is made in 64-bit mode. Each request produces a registered result one cycle later: the address, a fault flag, and the selector of the segment that was used.

The code segment is special. A load to it is accepted only when a control-transfer strobe comes with the load. Any other load to the code segment is refused and flagged as an error.

Top module: `seg_addr_gen`

## Requirements
- R1: There are six entries, indexed 0 to 5 in this order: ES, CS, SS, DS, FS, GS. An accepted load writes the selector, base and limit into the indexed entry, and `ld_err` stays low. For every index except CS, `ld_xfer` has no effect on a load. A request returns the stored selector on `out_sel`.
- R2: `out_vld` goes high exactly one cycle after each cycle in which `req_vld` is high, and it is low otherwise. `out_addr`, `out_fault` and `out_sel` belong to that request.
- R3: In 64-bit mode (`long_mode`=1), requests to ES, CS, SS or DS return the full 64-bit offset as the address, whatever base is stored for that segment.
- R4: In 64-bit mode, requests to FS or GS return the stored 64-bit base plus the offset, modulo 2^64.
- R5: In legacy mode (`long_mode`=0), the address is base[31:0] plus offset[31:0], modulo 2^32. Address bits 63:32 are zero, and offset bits 63:32 are ignored.
- R6: In legacy mode, `out_fault` is high when offset[31:0] is greater than the stored 32-bit limit. An offset equal to the limit does not fault.
- R7: In 64-bit mode, `out_fault` is low for every valid index, even when the offset is beyond the stored limit.
- R8: A CS load (index 1) is accepted only when `ld_xfer` is high. A CS load without `ld_xfer` leaves the entry unchanged and raises `ld_err` for one cycle, in the cycle after the load.
- R9: Index 6 or 7 is invalid. A load to an invalid index writes nothing and raises `ld_err` on the next cycle. A request to an invalid index, in either mode, gives `out_fault`=1, `out_addr`=0 and `out_sel`=0.
- R10: Stored entries are not altered by the mode input, so legacy results after a period in 64-bit mode again use the stored base and limit.
- R11: A load and a request to the same index in the same cycle: the request sees the entry as it was before the load, and the next request sees the new entry.
- R12: Reset is synchronous and active high. It clears every entry (selector, base and limit all zero) and drives `out_vld`, `out_fault` and `ld_err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| long_mode | input | 1 | 1 = 64-bit address rules, 0 = legacy rules |
| ld_en | input | 1 | Load strobe for one table entry |
| ld_idx | input | 3 | Index of the entry to load |
| ld_xfer | input | 1 | Control-transfer strobe; needed for a CS load |
| ld_sel | input | 16 | Selector to store |
| ld_base | input | 64 | Base to store |
| ld_limit | input | 32 | Limit to store |
| ld_err | output | 1 | Pulses one cycle after a refused load |
| req_vld | input | 1 | Address request strobe |
| req_idx | input | 3 | Segment index of the request |
| req_ofs | input | 64 | Effective-address offset |
| out_vld | output | 1 | Result strobe, one cycle after `req_vld` |
| out_addr | output | 64 | Linear address |
| out_fault | output | 1 | Limit or index fault |
| out_sel | output | 16 | Selector of the segment used |

## Verification
The properties assume that `long_mode` and `req_idx` are steady within the cycle in which a request is sampled. They also assume that `ld_idx` is a 3-bit code whose values 6 and 7 mean no segment. The stimulus changes every input only on the falling clock edge, so each rising edge samples a stable, fully defined set of load and request fields. Unused fields are held at zero between operations, so no X reaches the table or the adder paths.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [2:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_id_e;

  localparam int NUM_SEGS = 6;

  // segments whose base is ignored under 64-bit rules
  function automatic logic is_flat_seg(input logic [2:0] idx);
    return (idx == SEG_ES) || (idx == SEG_CS) || (idx == SEG_SS) || (idx == SEG_DS);
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_pkg::*;
#(
  parameter int NSEG   = NUM_SEGS,
  parameter int IDX_W  = 3,
  parameter int SEL_W  = 16,
  parameter int BASE_W = 64,
  parameter int LIM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic              ld_xfer,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [BASE_W-1:0] ld_base,
  input  logic [LIM_W-1:0]  ld_limit,
  output logic              ld_err,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_hit,
  output logic [SEL_W-1:0]  rd_sel,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_limit
);

  logic [SEL_W-1:0]  sel_q  [NSEG];
  logic [BASE_W-1:0] base_q [NSEG];
  logic [LIM_W-1:0]  lim_q  [NSEG];

  logic ld_idx_ok;
  logic ld_accept;

  assign ld_idx_ok = (32'(ld_idx) < NSEG);
  assign ld_accept = ld_en && ld_idx_ok && ((ld_idx != IDX_W'(SEG_CS)) || ld_xfer);

  for (genvar g = 0; g < NSEG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[g]  <= '0;
        base_q[g] <= '0;
        lim_q[g]  <= '0;
      end else if (ld_accept && (32'(ld_idx) == g)) begin
        sel_q[g]  <= ld_sel;
        base_q[g] <= ld_base;
        lim_q[g]  <= ld_limit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ld_err <= 1'b0;
    else     ld_err <= ld_en && !ld_accept;
  end

  // read side returns pre-write contents during a same-cycle load
  always_comb begin
    rd_hit   = 1'b0;
    rd_sel   = '0;
    rd_base  = '0;
    rd_limit = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (32'(rd_idx) == i) begin
        rd_hit   = 1'b1;
        rd_sel   = sel_q[i];
        rd_base  = base_q[i];
        rd_limit = lim_q[i];
      end
    end
  end

endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
  import seg_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 64,
  parameter int LEG_W  = 32,
  parameter int LIM_W  = 32
) (
  input  logic              long_mode,
  input  logic [IDX_W-1:0]  idx,
  input  logic              hit,
  input  logic [ADDR_W-1:0] base,
  input  logic [LIM_W-1:0]  limit,
  input  logic [ADDR_W-1:0] ofs,
  output logic [ADDR_W-1:0] addr,
  output logic              fault
);

  localparam int HI_W = ADDR_W - LEG_W;

  logic [LEG_W-1:0]  leg_sum;
  logic              leg_over;
  logic [ADDR_W-1:0] long_base;
  logic [ADDR_W-1:0] long_sum;

  assign leg_sum   = base[LEG_W-1:0] + ofs[LEG_W-1:0];
  assign leg_over  = ADDR_W'(ofs[LEG_W-1:0]) > ADDR_W'(limit);
  assign long_base = is_flat_seg(3'(idx)) ? '0 : base;
  assign long_sum  = long_base + ofs;

  always_comb begin
    if (!hit) begin
      addr  = '0;
      fault = 1'b1;
    end else if (long_mode) begin
      addr  = long_sum;
      fault = 1'b0;
    end else begin
      addr  = {{HI_W{1'b0}}, leg_sum};
      fault = leg_over;
    end
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
#(
  parameter int NSEG   = NUM_SEGS,
  parameter int IDX_W  = 3,
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 64,
  parameter int LEG_W  = 32,
  parameter int LIM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              long_mode,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic              ld_xfer,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [ADDR_W-1:0] ld_base,
  input  logic [LIM_W-1:0]  ld_limit,
  output logic              ld_err,
  input  logic              req_vld,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [ADDR_W-1:0] req_ofs,
  output logic              out_vld,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_fault,
  output logic [SEL_W-1:0]  out_sel
);

  logic              rd_hit;
  logic [SEL_W-1:0]  rd_sel;
  logic [ADDR_W-1:0] rd_base;
  logic [LIM_W-1:0]  rd_limit;
  logic [ADDR_W-1:0] calc_addr;
  logic              calc_fault;

  seg_table #(
    .NSEG(NSEG), .IDX_W(IDX_W), .SEL_W(SEL_W), .BASE_W(ADDR_W), .LIM_W(LIM_W)
  ) table_i (
    .clk      (clk),
    .rst      (rst),
    .ld_en    (ld_en),
    .ld_idx   (ld_idx),
    .ld_xfer  (ld_xfer),
    .ld_sel   (ld_sel),
    .ld_base  (ld_base),
    .ld_limit (ld_limit),
    .ld_err   (ld_err),
    .rd_idx   (req_idx),
    .rd_hit   (rd_hit),
    .rd_sel   (rd_sel),
    .rd_base  (rd_base),
    .rd_limit (rd_limit)
  );

  seg_addr_calc #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LEG_W(LEG_W), .LIM_W(LIM_W)
  ) calc_i (
    .long_mode (long_mode),
    .idx       (req_idx),
    .hit       (rd_hit),
    .base      (rd_base),
    .limit     (rd_limit),
    .ofs       (req_ofs),
    .addr      (calc_addr),
    .fault     (calc_fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_addr  <= '0;
      out_fault <= 1'b0;
      out_sel   <= '0;
    end else begin
      out_vld <= req_vld;
      if (req_vld) begin
        out_addr  <= calc_addr;
        out_fault <= calc_fault;
        out_sel   <= rd_sel;
      end
    end
  end

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 64,
  parameter int LEG_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              long_mode,
  input logic              ld_en,
  input logic [IDX_W-1:0]  ld_idx,
  input logic              ld_xfer,
  input logic              ld_err,
  input logic              req_vld,
  input logic [IDX_W-1:0]  req_idx,
  input logic [ADDR_W-1:0] req_ofs,
  input logic              out_vld,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_fault
);

  AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> out_vld);  // R2

  AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !out_vld);  // R2

  AST_FLAT_ADDR: assert property (@(posedge clk) disable iff (rst)
    (req_vld && long_mode && (req_idx <= IDX_W'(3))) |=> (out_addr == $past(req_ofs)));  // R3

  AST_LEGACY_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !long_mode) |=> (out_addr[ADDR_W-1:LEG_W] == '0));  // R5

  AST_LONG_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_vld && long_mode && (req_idx <= IDX_W'(5))) |=> !out_fault);  // R7

  AST_CS_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (ld_en && (ld_idx == IDX_W'(1)) && !ld_xfer) |=> ld_err);  // R8

  AST_BAD_IDX_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_vld && (req_idx > IDX_W'(5))) |=> (out_fault && (out_addr == '0)));  // R9

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LEG_W(LEG_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .long_mode (long_mode),
  .ld_en     (ld_en),
  .ld_idx    (ld_idx),
  .ld_xfer   (ld_xfer),
  .ld_err    (ld_err),
  .req_vld   (req_vld),
  .req_idx   (req_idx),
  .req_ofs   (req_ofs),
  .out_vld   (out_vld),
  .out_addr  (out_addr),
  .out_fault (out_fault)
);

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        long_mode;
  logic        ld_en;
  logic [2:0]  ld_idx;
  logic        ld_xfer;
  logic [15:0] ld_sel;
  logic [63:0] ld_base;
  logic [31:0] ld_limit;
  logic        ld_err;
  logic        req_vld;
  logic [2:0]  req_idx;
  logic [63:0] req_ofs;
  logic        out_vld;
  logic [63:0] out_addr;
  logic        out_fault;
  logic [15:0] out_sel;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  seg_addr_gen dut_i (
    .clk(clk), .rst(rst), .long_mode(long_mode),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_xfer(ld_xfer), .ld_sel(ld_sel),
    .ld_base(ld_base), .ld_limit(ld_limit), .ld_err(ld_err),
    .req_vld(req_vld), .req_idx(req_idx), .req_ofs(req_ofs),
    .out_vld(out_vld), .out_addr(out_addr), .out_fault(out_fault), .out_sel(out_sel)
  );

  typedef struct packed {
    logic        is_req;
    logic        lng;
    logic        xfer;
    logic [2:0]  idx;
    logic [15:0] sel;
    logic [63:0] base;
    logic [31:0] lim;
    logic [63:0] ofs;
    logic [63:0] e_addr;
    logic        e_fault;
    logic [15:0] e_sel;
    logic        e_err;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    // R1 load DS
    '{1'b0,1'b0,1'b0,3'd3,16'h0023,64'h0000_0000_1000_0000,32'h0000_FFFF,64'h0,64'h0,1'b0,16'h0,1'b0,8'd1},
    // R5 legacy DS
    '{1'b1,1'b0,1'b0,3'd3,16'h0,64'h0,32'h0,64'h10,64'h0000_0000_1000_0010,1'b0,16'h0023,1'b0,8'd5},
    // R6 offset equal to limit
    '{1'b1,1'b0,1'b0,3'd3,16'h0,64'h0,32'h0,64'hFFFF,64'h0000_0000_1000_FFFF,1'b0,16'h0023,1'b0,8'd6},
    // R6 offset above limit
    '{1'b1,1'b0,1'b0,3'd3,16'h0,64'h0,32'h0,64'h1_0000,64'h0000_0000_1001_0000,1'b1,16'h0023,1'b0,8'd6},
    // R1 load FS
    '{1'b0,1'b0,1'b0,3'd4,16'h0053,64'hFFFF_8000_0000_1000,32'h0000_0FFF,64'h0,64'h0,1'b0,16'h0,1'b0,8'd1},
    // R5 legacy FS, high offset bits ignored
    '{1'b1,1'b0,1'b0,3'd4,16'h0,64'h0,32'h0,64'hFFFF_FFFF_0000_0010,64'h0000_0000_0000_1010,1'b0,16'h0053,1'b0,8'd5},
    // R4 long FS
    '{1'b1,1'b1,1'b0,3'd4,16'h0,64'h0,32'h0,64'h10,64'hFFFF_8000_0000_1010,1'b0,16'h0053,1'b0,8'd4},
    // R7 long FS beyond limit
    '{1'b1,1'b1,1'b0,3'd4,16'h0,64'h0,32'h0,64'h2000,64'hFFFF_8000_0000_3000,1'b0,16'h0053,1'b0,8'd7},
    // R3 long DS flat
    '{1'b1,1'b1,1'b0,3'd3,16'h0,64'h0,32'h0,64'h0000_1234_5678_9ABC,64'h0000_1234_5678_9ABC,1'b0,16'h0023,1'b0,8'd3},
    // R8 CS load without transfer strobe
    '{1'b0,1'b0,1'b0,3'd1,16'h0008,64'h500,32'hFF,64'h0,64'h0,1'b0,16'h0,1'b1,8'd8},
    // R8 CS unchanged
    '{1'b1,1'b0,1'b0,3'd1,16'h0,64'h0,32'h0,64'h0,64'h0,1'b0,16'h0000,1'b0,8'd8},
    // R8 CS load with transfer strobe
    '{1'b0,1'b0,1'b1,3'd1,16'h0008,64'h500,32'hFF,64'h0,64'h0,1'b0,16'h0,1'b0,8'd8},
    // R8 CS now loaded, R6 over limit
    '{1'b1,1'b0,1'b0,3'd1,16'h0,64'h0,32'h0,64'h100,64'h600,1'b1,16'h0008,1'b0,8'd8},
    // R10 legacy DS again after 64-bit use
    '{1'b1,1'b0,1'b0,3'd3,16'h0,64'h0,32'h0,64'h0,64'h0000_0000_1000_0000,1'b0,16'h0023,1'b0,8'd10},
    // R9 load to index 6
    '{1'b0,1'b0,1'b1,3'd6,16'h0077,64'h123,32'h5,64'h0,64'h0,1'b0,16'h0,1'b1,8'd9},
    // R9 request index 7 legacy
    '{1'b1,1'b0,1'b0,3'd7,16'h0,64'h0,32'h0,64'h40,64'h0,1'b1,16'h0000,1'b0,8'd9},
    // R9 request index 6 long
    '{1'b1,1'b1,1'b0,3'd6,16'h0,64'h0,32'h0,64'h40,64'h0,1'b1,16'h0000,1'b0,8'd9},
    // R1 load GS
    '{1'b0,1'b0,1'b0,3'd5,16'h002B,64'h0000_0000_FFFF_FFFF,32'hFFFF_FFFF,64'h0,64'h0,1'b0,16'h0,1'b0,8'd1},
    // R5 legacy wrap at 2^32
    '{1'b1,1'b0,1'b0,3'd5,16'h0,64'h0,32'h0,64'h2,64'h0000_0000_0000_0001,1'b0,16'h002B,1'b0,8'd5},
    // R4 long GS carries past 32 bits
    '{1'b1,1'b1,1'b0,3'd5,16'h0,64'h0,32'h0,64'h2,64'h0000_0001_0000_0001,1'b0,16'h002B,1'b0,8'd4},
    // R1 load ES with transfer strobe set (no effect)
    '{1'b0,1'b0,1'b1,3'd0,16'h0010,64'h2_0000,32'h10,64'h0,64'h0,1'b0,16'h0,1'b0,8'd1},
    // R3 long ES flat, R7 no fault
    '{1'b1,1'b1,1'b0,3'd0,16'h0,64'h0,32'h0,64'h50,64'h50,1'b0,16'h0010,1'b0,8'd3}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ld_en = 1'b0; ld_idx = '0; ld_xfer = 1'b0; ld_sel = '0; ld_base = '0; ld_limit = '0;
    req_vld = 1'b0; req_idx = '0; req_ofs = '0;
  endtask

  task automatic do_load(input logic [2:0] idx, input logic xfer, input logic [15:0] sel,
                         input logic [63:0] base, input logic [31:0] lim,
                         input logic e_err, input string tag);
    ld_en = 1'b1; ld_idx = idx; ld_xfer = xfer; ld_sel = sel; ld_base = base; ld_limit = lim;
    @(negedge clk);
    idle_inputs();
    check({tag, " ld_err"}, 64'(ld_err), 64'(e_err));
  endtask

  task automatic do_req(input logic lng, input logic [2:0] idx, input logic [63:0] ofs,
                        input logic [63:0] e_addr, input logic e_fault, input logic [15:0] e_sel,
                        input string tag);
    long_mode = lng; req_vld = 1'b1; req_idx = idx; req_ofs = ofs;
    @(negedge clk);
    idle_inputs();
    check({tag, " out_vld"}, 64'(out_vld), 64'd1);
    check({tag, " out_addr"}, out_addr, e_addr);
    check({tag, " out_fault"}, 64'(out_fault), 64'(e_fault));
    check({tag, " out_sel"}, 64'(out_sel), 64'(e_sel));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    long_mode = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset values
    check("R12 out_vld", 64'(out_vld), 64'd0);
    check("R12 ld_err", 64'(ld_err), 64'd0);
    check("R12 out_fault", 64'(out_fault), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 idle out_vld", 64'(out_vld), 64'd0);
    // R12 entries cleared: base 0, limit 0
    do_req(1'b0, 3'd2, 64'h0, 64'h0, 1'b0, 16'h0, "R12 SS zero ofs");
    do_req(1'b0, 3'd2, 64'h1, 64'h1, 1'b1, 16'h0, "R12 SS limit zero");

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].rq, i);
      if (VECS[i].is_req)
        do_req(VECS[i].lng, VECS[i].idx, VECS[i].ofs, VECS[i].e_addr, VECS[i].e_fault,
               VECS[i].e_sel, tag);
      else
        do_load(VECS[i].idx, VECS[i].xfer, VECS[i].sel, VECS[i].base, VECS[i].lim,
                VECS[i].e_err, tag);
    end

    // R8 error pulse lasts one cycle
    check("R8 ld_err pulse end", 64'(ld_err), 64'd0);

    // R11 same-cycle load and request to DS
    long_mode = 1'b0;
    ld_en = 1'b1; ld_idx = 3'd3; ld_xfer = 1'b0; ld_sel = 16'h0033;
    ld_base = 64'h7000_0000; ld_limit = 32'h0;
    req_vld = 1'b1; req_idx = 3'd3; req_ofs = 64'h20;
    @(negedge clk);
    idle_inputs();
    check("R11 old addr", out_addr, 64'h1000_0020);
    check("R11 old fault", 64'(out_fault), 64'd0);
    check("R11 old sel", 64'(out_sel), 64'h0023);
    check("R11 load err", 64'(ld_err), 64'd0);
    do_req(1'b0, 3'd3, 64'h20, 64'h7000_0020, 1'b1, 16'h0033, "R11 new entry");

    // R2 back-to-back requests then idle
    long_mode = 1'b1; req_vld = 1'b1; req_idx = 3'd4; req_ofs = 64'h1;
    @(negedge clk);
    req_idx = 3'd0; req_ofs = 64'h99;
    check("R2 b2b first", out_addr, 64'hFFFF_8000_0000_1001);
    @(negedge clk);
    idle_inputs();
    check("R2 b2b second", out_addr, 64'h99);
    check("R2 b2b vld", 64'(out_vld), 64'd1);
    @(negedge clk);
    check("R2 drop vld", 64'(out_vld), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule